// File: doc/BRIEF.md
# Packed Byte Dot-Product with Saturating Accumulate

The block takes two 32-bit words, each split into four 8-bit lanes, and forms the sum of the four lane-by-lane products. It then adds that sum to a wide accumulator input. Only this final accumulate step clamps at the limits of the result width. The individual lane products and the sum of the four products are formed exactly, in an internal width that has room for every possible value.

A two-bit mode input picks how the lanes are read. In one setting both words hold signed bytes. In another, the first word holds signed bytes and the second word holds unsigned bytes. In the third, both words hold unsigned bytes. The result and the accumulator share one parameterised width of 32 or 64 bits.

Operands enter with a valid strobe. One clock later the clamped result appears on a register, together with a valid strobe and a flag that says whether clamping happened on that result.

Top module: `dpa_top`

## Requirements
- R1: With `in_mode` = 2'b00, every byte lane of both `in_a` and `in_b` is taken as a two's-complement value. Lane k occupies bits [8k+7:8k] of each word.
- R2: With `in_mode` = 2'b01, the lanes of `in_a` are taken as signed and the lanes of `in_b` as unsigned (0 to 255).
- R3: With `in_mode` = 2'b10 or 2'b11, the lanes of both words are taken as unsigned, and both codes give identical results.
- R4: The four products and their sum are never clamped. A lane sum that exceeds 16 bits reaches the accumulate step unchanged.
- R5: In the two signed modes, a total above the largest two's-complement value of the result width gives that largest value and raises `out_sat`.
- R6: In the two signed modes, a total below the smallest two's-complement value gives that smallest value and raises `out_sat`. A total equal to the smallest value is passed through without the flag.
- R7: In unsigned mode, a total above 2^RES_W-1 gives all ones and raises `out_sat`. A total equal to 2^RES_W-1 is passed through without the flag.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_result` and `out_sat`, and it takes priority over a valid input in the same cycle.
- R10: `out_sat` describes only the result beside it. It falls on the next result that needs no clamping.
- R11: While `in_valid` is low, `out_result` and `out_sat` hold their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| in_a | input | 32 | First packed operand, four byte lanes |
| in_b | input | 32 | Second packed operand, four byte lanes |
| in_mode | input | 2 | Lane signedness select: 00 signed, 01 signed by unsigned, 1x unsigned |
| in_acc | input | RES_W | Accumulator added to the lane sum |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | RES_W | Clamped accumulate result |
| out_sat | output | 1 | High when `out_result` was clamped |

## Verification
The bench builds the block with RES_W = 32. At this width both clamp limits can be reached with small, hand-checkable lane sums: an accumulator a few tens of thousands below 2^31-1, at -2^31, or near 2^32-1 crosses the limit. The table walks each limit one step inside and one step past, and it includes lane patterns whose product sum needs more than 16 bits. Each pattern is applied in a mode where a wrong choice of sign or zero extension changes the answer.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    DPA_SS     = 2'b00,
    DPA_SU     = 2'b01,
    DPA_UU     = 2'b10,
    DPA_UU_ALT = 2'b11
  } dpa_mode_e;

  // Lane A is read as signed in both the signed and the mixed mode.
  function automatic logic a_is_signed(input logic [1:0] mode);
    return (mode == DPA_SS) || (mode == DPA_SU);
  endfunction

  // Lane B is read as signed only in the fully signed mode.
  function automatic logic b_is_signed(input logic [1:0] mode);
    return mode == DPA_SS;
  endfunction

  // Clamping uses the unsigned range for both unsigned codes.
  function automatic logic uses_unsigned_range(input logic [1:0] mode);
    return mode[1];
  endfunction

endpackage

// File: rtl/dpa_lane_mul.sv
module dpa_lane_mul #(
  parameter int LANE_W = 8,
  parameter int EXT_W  = LANE_W + 1,
  parameter int PROD_W = 2 * EXT_W
) (
  input  logic [LANE_W-1:0] a_lane,
  input  logic [LANE_W-1:0] b_lane,
  input  logic              a_sgn,
  input  logic              b_sgn,
  output logic [PROD_W-1:0] prod
);

  // One extra bit carries either the sign or a zero, so a single
  // signed multiplier serves every signedness mix.
  logic signed [EXT_W-1:0]  a_ext;
  logic signed [EXT_W-1:0]  b_ext;
  logic signed [PROD_W-1:0] p_s;

  always_comb begin
    a_ext = {a_sgn & a_lane[LANE_W-1], a_lane};
    b_ext = {b_sgn & b_lane[LANE_W-1], b_lane};
    p_s   = a_ext * b_ext;
    prod  = p_s;
  end

endmodule

// File: rtl/dpa_lane_sum.sv
module dpa_lane_sum #(
  parameter int LANES  = 4,
  parameter int PROD_W = 18,
  parameter int SUM_W  = PROD_W + $clog2(LANES)
) (
  input  logic [LANES*PROD_W-1:0] prods,
  output logic [SUM_W-1:0]        sum
);

  logic [PROD_W-1:0] p [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign p[g] = prods[g*PROD_W +: PROD_W];
  end

  // Exact sum: SUM_W leaves room for LANES worst-case products.
  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) begin
      sum = sum + {{(SUM_W-PROD_W){p[i][PROD_W-1]}}, p[i]};
    end
  end

endmodule

// File: rtl/dpa_sat_add.sv
module dpa_sat_add #(
  parameter int RES_W = 32,
  parameter int SUM_W = 20
) (
  input  logic [RES_W-1:0] acc,
  input  logic [SUM_W-1:0] lane_sum,
  input  logic             uns,
  output logic [RES_W-1:0] result,
  output logic             sat
);

  localparam int WIDE_W = RES_W + 1;
  localparam logic [RES_W-1:0] SMAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] SMIN = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] UMAX = {RES_W{1'b1}};

  logic [WIDE_W-1:0] acc_w;
  logic [WIDE_W-1:0] sum_w;
  logic [WIDE_W-1:0] total;

  always_comb begin
    acc_w = {(uns ? 1'b0 : acc[RES_W-1]), acc};
    sum_w = {{(WIDE_W-SUM_W){lane_sum[SUM_W-1]}}, lane_sum};
    total = acc_w + sum_w;
    if (uns) begin
      // The lane sum is never negative here, so only a carry out can occur.
      sat    = total[RES_W];
      result = total[RES_W] ? UMAX : total[RES_W-1:0];
    end else begin
      sat    = total[RES_W] ^ total[RES_W-1];
      result = !sat ? total[RES_W-1:0] : (total[RES_W] ? SMIN : SMAX);
    end
  end

endmodule

// File: rtl/dpa_top.sv
module dpa_top
  import dpa_pkg::*;
#(
  parameter int RES_W  = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] in_a,
  input  logic [LANES*LANE_W-1:0] in_b,
  input  logic [1:0]              in_mode,
  input  logic [RES_W-1:0]        in_acc,
  output logic                    out_valid,
  output logic [RES_W-1:0]        out_result,
  output logic                    out_sat
);

  localparam int EXT_W  = LANE_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int SUM_W  = PROD_W + $clog2(LANES);

  logic                    a_sgn;
  logic                    b_sgn;
  logic                    uns;
  logic [LANES*PROD_W-1:0] prods;
  logic [SUM_W-1:0]        lane_sum;
  logic [RES_W-1:0]        sat_res;
  logic                    sat_hit;

  always_comb begin
    a_sgn = a_is_signed(in_mode);
    b_sgn = b_is_signed(in_mode);
    uns   = uses_unsigned_range(in_mode);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpa_lane_mul #(
      .LANE_W (LANE_W),
      .EXT_W  (EXT_W),
      .PROD_W (PROD_W)
    ) u_mul (
      .a_lane (in_a[g*LANE_W +: LANE_W]),
      .b_lane (in_b[g*LANE_W +: LANE_W]),
      .a_sgn  (a_sgn),
      .b_sgn  (b_sgn),
      .prod   (prods[g*PROD_W +: PROD_W])
    );
  end

  dpa_lane_sum #(
    .LANES  (LANES),
    .PROD_W (PROD_W),
    .SUM_W  (SUM_W)
  ) u_sum (
    .prods (prods),
    .sum   (lane_sum)
  );

  dpa_sat_add #(
    .RES_W (RES_W),
    .SUM_W (SUM_W)
  ) u_sat (
    .acc      (in_acc),
    .lane_sum (lane_sum),
    .uns      (uns),
    .result   (sat_res),
    .sat      (sat_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_sat    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= sat_res;
        out_sat    <= sat_hit;
      end
    end
  end

endmodule

// File: rtl/dpa_top_chk.sv
module dpa_top_chk #(
  parameter int RES_W = 32,
  parameter int OP_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [OP_W-1:0]  in_a,
  input logic [OP_W-1:0]  in_b,
  input logic [1:0]       in_mode,
  input logic [RES_W-1:0] in_acc,
  input logic             out_valid,
  input logic [RES_W-1:0] out_result,
  input logic             out_sat
);

  localparam logic [RES_W-1:0] SMAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] SMIN = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] UMAX = {RES_W{1'b1}};

  // R8: the output strobe follows the input strobe by one clock
  a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R11: no new operands means the result and flag keep their values
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_sat)));

  // R7: an unsigned clamp lands exactly on all ones
  a_r7_unsigned_clamp: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode[1]) |=> (!out_sat || out_result == UMAX));

  // R5 and R6: a signed clamp lands on one of the two signed limits
  a_r5_r6_signed_clamp: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_mode[1]) |=>
      (!out_sat || out_result == SMAX || out_result == SMIN));

  // R10: an unclamped unsigned result never falls below its accumulator
  a_r10_unsigned_grow: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sat && $past(in_mode[1])) |->
      (out_result >= $past(in_acc)));

endmodule

bind dpa_top dpa_top_chk #(
  .RES_W (RES_W),
  .OP_W  (LANES*LANE_W)
) u_dpa_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_a       (in_a),
  .in_b       (in_b),
  .in_mode    (in_mode),
  .in_acc     (in_acc),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_sat    (out_sat)
);

// File: tb/dpa_top_test.sv
module dpa_top_test;

  localparam int RES_W = 32;
  localparam int NV    = 13;

  // Entry: {mode, a, b, acc, expected result, expected flag}
  localparam logic [130:0] VECS [NV] = '{
    {2'b00, 32'h01020304, 32'h05060708, 32'h0000000A, 32'h00000050, 1'b0},
    {2'b00, 32'hFFFFFFFF, 32'h02020202, 32'h00000000, 32'hFFFFFFF8, 1'b0},
    {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFC04, 1'b0},
    {2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0003F804, 1'b0},
    {2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0003F804, 1'b0},
    {2'b00, 32'h80808080, 32'h80808080, 32'h7FFEFFFF, 32'h7FFFFFFF, 1'b0},
    {2'b00, 32'h80808080, 32'h80808080, 32'h7FFF0000, 32'h7FFFFFFF, 1'b1},
    {2'b01, 32'h80808080, 32'hFFFFFFFF, 32'h80000000, 32'h80000000, 1'b1},
    {2'b00, 32'hFFFFFFFF, 32'h01010101, 32'h80000004, 32'h80000000, 1'b0},
    {2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},
    {2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFC07FB, 32'hFFFFFFFF, 1'b0},
    {2'b01, 32'h000000FF, 32'h000000FF, 32'h00000000, 32'hFFFFFF01, 1'b0},
    {2'b10, 32'h000000FF, 32'h000000FF, 32'h80000000, 32'h8000FE01, 1'b0}
  };

  localparam string TAGS [NV] = '{
    "R1", "R1", "R2", "R3", "R3", "R4", "R5",
    "R6", "R6", "R7", "R10", "R2", "R3"
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [31:0]      in_a;
  logic [31:0]      in_b;
  logic [1:0]       in_mode;
  logic [RES_W-1:0] in_acc;
  logic             out_valid;
  logic [RES_W-1:0] out_result;
  logic             out_sat;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dpa_top #(.RES_W(RES_W)) uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_mode    (in_mode),
    .in_acc     (in_acc),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_sat    (out_sat)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] m,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [RES_W-1:0] acc);
    in_valid = v;
    in_mode  = m;
    in_a     = a;
    in_b     = b;
    in_acc   = acc;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 2'b00, 32'h0, 32'h0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: state after reset
    check("R9", "valid", {63'd0, out_valid}, 64'd0);
    check("R9", "result", {32'd0, out_result}, 64'd0);
    check("R9", "flag", {63'd0, out_sat}, 64'd0);

    rst = 1'b0;
    // Table walk: one vector per clock, streamed back to back
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i][130:129], VECS[i][128:97], VECS[i][96:65],
            VECS[i][64:33]);
      @(negedge clk);
      check("R8", "valid", {63'd0, out_valid}, 64'd1);
      check(TAGS[i], "result", {32'd0, out_result}, {32'd0, VECS[i][32:1]});
      check(TAGS[i], "flag", {63'd0, out_sat}, {63'd0, VECS[i][0]});
    end

    // R11: idle inputs that would saturate must not disturb the output
    drive(1'b0, 2'b00, 32'h80808080, 32'h80808080, 32'h7FFFFFFF);
    @(negedge clk);
    check("R8", "idle valid", {63'd0, out_valid}, 64'd0);
    check("R11", "held result", {32'd0, out_result}, 64'h8000FE01);
    check("R11", "held flag", {63'd0, out_sat}, 64'd0);
    drive(1'b0, 2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    @(negedge clk);
    check("R11", "held result 2", {32'd0, out_result}, 64'h8000FE01);
    check("R11", "held flag 2", {63'd0, out_sat}, 64'd0);

    // R5 again after an idle gap, then R10 flag drops on the next result
    drive(1'b1, 2'b00, 32'h80808080, 32'h80808080, 32'h7FFFFFFF);
    @(negedge clk);
    check("R5", "clamp after idle", {32'd0, out_result}, 64'h7FFFFFFF);
    check("R5", "flag after idle", {63'd0, out_sat}, 64'd1);
    drive(1'b1, 2'b00, 32'h00000000, 32'h00000000, 32'h7FFFFFFF);
    @(negedge clk);
    check("R10", "flag clears", {63'd0, out_sat}, 64'd0);
    check("R10", "max passes", {32'd0, out_result}, 64'h7FFFFFFF);

    // R9: reset wins over a valid input in the same cycle
    drive(1'b1, 2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "reset valid", {63'd0, out_valid}, 64'd0);
    check("R9", "reset result", {32'd0, out_result}, 64'd0);
    check("R9", "reset flag", {63'd0, out_sat}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule